// File: doc/BRIEF.md
# Loop Ratio Live-Update Synchronizer

This block keeps the multiplier setting of a clock-multiplying loop: an integer part and a fractional part. Software may rewrite the multiplier while the loop is running. Each write lands at once in a shadow copy, so it reads back in the next cycle. The new value reaches the loop only after a request/acknowledge handshake with the output clock domain, and a busy flag covers that whole interval.

A live update is accepted only when two settings allow it: the lock-bypass control must be low and the lock-time code must be nonzero. A write under any other setting still changes the shadow copy. It also raises a sticky error flag, cancels any forward still pending, and leaves the applied ratio unchanged. When an applied update changes the integer part, the block drops its lock status and raises it again at the next lock-timer expiry. A change to the fractional part alone keeps lock.

The control is a three-state machine:
- `S_RELOCK` is the reset state. Lock is low and the block waits for the timer.
- `S_IDLE` means the loop is locked and no transfer is open.
- `S_XFER` means a request is open toward the output domain.

The transitions are:
- RELOCK→XFER when a forward is pending. This has priority over a timer expiry in the same cycle.
- RELOCK→IDLE on a timer expiry with nothing pending. This sets lock.
- IDLE→XFER when a forward is pending.
- XFER→RELOCK on an acknowledge when the integer part changes or lock is already low.
- XFER→IDLE on an acknowledge in all other cases.

Top module: `ratio_update_sync`

## Requirements
- R1: In the cycle after a write, the readback outputs show the written integer and fractional values, whatever the bypass and lock-time settings are.
- R2: A valid write (bypass 0, lock-time code nonzero) raises busy in the cycle after the write. Busy falls in the cycle after the acknowledge when no newer valid write is pending.
- R3: The request rises one cycle after busy does, and it stays high until an acknowledge is sampled. The applied ratio changes only on the clock edge where request and acknowledge are both high, and it then takes the forwarded value.
- R4: An acknowledged update whose integer part differs from the applied integer part clears lock in the same clock edge.
- R5: An acknowledged update that changes only the fractional part leaves lock unchanged.
- R6: After reset, lock is 0. Lock becomes 1 only at a lock-timer expiry while the block is waiting to relock.
- R7: A write made while bypass is 1 or the lock-time code is 0 sets the sticky error flag. It does not set busy or request, and it leaves the applied ratio unchanged.
- R8: Valid writes made while a transfer is open are held. After the acknowledge, only the most recent one is forwarded.
- R9: Reset clears readback, applied ratio, busy, request and error to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_int_i | input | INT_W | Integer part to write |
| wr_frac_i | input | FRAC_W | Fractional part to write |
| bypass_i | input | 1 | Lock-bypass setting (1 forbids live update) |
| ltime_i | input | LTIME_W | Lock-time code (0 forbids live update) |
| ack_i | input | 1 | Acknowledge from the output clock domain |
| tmr_expire_i | input | 1 | Lock-timer expiry pulse |
| rd_int_o | output | INT_W | Readback of the integer part |
| rd_frac_o | output | FRAC_W | Readback of the fractional part |
| busy_o | output | 1 | Ratio synchronization busy |
| req_o | output | 1 | Transfer request to the output clock domain |
| app_int_o | output | INT_W | Integer part applied to the loop |
| app_frac_o | output | FRAC_W | Fractional part applied to the loop |
| lock_o | output | 1 | Lock status |
| upd_err_o | output | 1 | Sticky error for a live update under invalid settings |

## Verification
The bench builds the block with INT_W=4, FRAC_W=2 and LTIME_W=2. At these sizes it can walk every one of the 64 integer/fractional combinations in turn. That walk covers both integer-changing and fraction-only updates against an arithmetic model of the lock. A 2-bit lock-time code also lets all eight bypass/lock-time combinations be tried. Queued writes during an open transfer are checked for last-value-wins forwarding.

// File: rtl/ratio_sync_pkg.sv
package ratio_sync_pkg;
    typedef enum logic [1:0] {
        S_RELOCK = 2'd0,
        S_IDLE   = 2'd1,
        S_XFER   = 2'd2
    } sync_state_t;
endpackage

// File: rtl/ratio_shadow.sv
module ratio_shadow #(
    parameter int INT_W   = 13,
    parameter int FRAC_W  = 5,
    parameter int LTIME_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               wr_en_i,
    input  logic [INT_W-1:0]   wr_int_i,
    input  logic [FRAC_W-1:0]  wr_frac_i,
    input  logic               bypass_i,
    input  logic [LTIME_W-1:0] ltime_i,
    input  logic               launch_i,
    output logic [INT_W-1:0]   shd_int_o,
    output logic [FRAC_W-1:0]  shd_frac_o,
    output logic               pending_o,
    output logic               upd_err_o
);
    logic live_ok;
    assign live_ok = !bypass_i && (ltime_i != '0);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            shd_int_o  <= '0;
            shd_frac_o <= '0;
            pending_o  <= 1'b0;
            upd_err_o  <= 1'b0;
        end else if (wr_en_i) begin
            shd_int_o  <= wr_int_i;
            shd_frac_o <= wr_frac_i;
            if (live_ok) begin
                pending_o <= 1'b1;
            end else begin
                pending_o <= 1'b0;
                upd_err_o <= 1'b1;
            end
        end else if (launch_i) begin
            pending_o <= 1'b0;
        end
    end

    assert_readback_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wr_en_i |=> (shd_int_o == $past(wr_int_i)) && (shd_frac_o == $past(wr_frac_i)));

    assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        upd_err_o |=> upd_err_o);

    assert_no_pend_on_bad_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wr_en_i && (bypass_i || ltime_i == '0)) |=> !pending_o);
endmodule

// File: rtl/ratio_sync_fsm.sv
module ratio_sync_fsm
    import ratio_sync_pkg::*;
#(
    parameter int INT_W  = 13,
    parameter int FRAC_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              pending_i,
    input  logic [INT_W-1:0]  shd_int_i,
    input  logic [FRAC_W-1:0] shd_frac_i,
    input  logic              ack_i,
    input  logic              tmr_expire_i,
    output logic              launch_o,
    output logic              req_o,
    output logic              xfer_o,
    output logic [INT_W-1:0]  app_int_o,
    output logic [FRAC_W-1:0] app_frac_o,
    output logic              lock_o
);
    sync_state_t state_q, state_d;
    logic [INT_W-1:0]  xfer_int_q;
    logic [FRAC_W-1:0] xfer_frac_q;
    logic int_chg;
    logic done;

    assign int_chg = (xfer_int_q != app_int_o);
    assign done    = (state_q == S_XFER) && ack_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RELOCK: if (pending_i)         state_d = S_XFER;
                      else if (tmr_expire_i) state_d = S_IDLE;
            S_IDLE:   if (pending_i)         state_d = S_XFER;
            S_XFER:   if (ack_i)             state_d = (int_chg || !lock_o) ? S_RELOCK : S_IDLE;
            default:                         state_d = S_RELOCK;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= S_RELOCK;
        else          state_q <= state_d;
    end

    always_comb begin
        req_o    = (state_q == S_XFER);
        xfer_o   = (state_q == S_XFER);
        launch_o = pending_i && (state_q != S_XFER);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            xfer_int_q  <= '0;
            xfer_frac_q <= '0;
            app_int_o   <= '0;
            app_frac_o  <= '0;
            lock_o      <= 1'b0;
        end else begin
            if (launch_o) begin
                xfer_int_q  <= shd_int_i;
                xfer_frac_q <= shd_frac_i;
            end
            if (done) begin
                app_int_o  <= xfer_int_q;
                app_frac_o <= xfer_frac_q;
                if (int_chg) lock_o <= 1'b0;
            end else if (state_q == S_RELOCK && tmr_expire_i && !pending_i) begin
                lock_o <= 1'b1;
            end
        end
    end

    assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (req_o && !ack_i) |=> req_o);

    assert_applied_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(req_o && ack_i) |=> ($stable(app_int_o) && $stable(app_frac_o)));

    assert_lock_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(lock_o) |-> $past(tmr_expire_i));

    assert_int_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (req_o && ack_i && (xfer_int_q != app_int_o)) |=> !lock_o);

    assert_frac_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (req_o && ack_i && (xfer_int_q == app_int_o) && lock_o) |=> lock_o);
endmodule

// File: rtl/ratio_update_sync.sv
module ratio_update_sync #(
    parameter int INT_W   = 13,
    parameter int FRAC_W  = 5,
    parameter int LTIME_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               wr_en_i,
    input  logic [INT_W-1:0]   wr_int_i,
    input  logic [FRAC_W-1:0]  wr_frac_i,
    input  logic               bypass_i,
    input  logic [LTIME_W-1:0] ltime_i,
    input  logic               ack_i,
    input  logic               tmr_expire_i,
    output logic [INT_W-1:0]   rd_int_o,
    output logic [FRAC_W-1:0]  rd_frac_o,
    output logic               busy_o,
    output logic               req_o,
    output logic [INT_W-1:0]   app_int_o,
    output logic [FRAC_W-1:0]  app_frac_o,
    output logic               lock_o,
    output logic               upd_err_o
);
    logic pending, launch, xfer;

    ratio_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LTIME_W(LTIME_W)) shadow_i (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_en_i(wr_en_i),
        .wr_int_i(wr_int_i), .wr_frac_i(wr_frac_i),
        .bypass_i(bypass_i), .ltime_i(ltime_i), .launch_i(launch),
        .shd_int_o(rd_int_o), .shd_frac_o(rd_frac_o),
        .pending_o(pending), .upd_err_o(upd_err_o)
    );

    ratio_sync_fsm #(.INT_W(INT_W), .FRAC_W(FRAC_W)) fsm_i (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .pending_i(pending),
        .shd_int_i(rd_int_o), .shd_frac_i(rd_frac_o),
        .ack_i(ack_i), .tmr_expire_i(tmr_expire_i),
        .launch_o(launch), .req_o(req_o), .xfer_o(xfer),
        .app_int_o(app_int_o), .app_frac_o(app_frac_o), .lock_o(lock_o)
    );

    assign busy_o = pending || xfer;

    assert_req_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        req_o |-> busy_o);
endmodule

// File: tb/ratio_update_sync_tb.sv
module ratio_update_sync_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 4;
    localparam int FW = 2;
    localparam int LW = 2;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IW-1:0] wr_int = '0;
    logic [FW-1:0] wr_frac = '0;
    logic bypass = 1'b0;
    logic [LW-1:0] ltime = 2'd1;
    logic ack = 1'b0;
    logic tmr = 1'b0;
    logic [IW-1:0] rd_int, app_int;
    logic [FW-1:0] rd_frac, app_frac;
    logic busy, req, lock, upd_err;

    int errors = 0;
    int checks = 0;
    int exp_int = 0;
    int exp_frac = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ratio_update_sync #(.INT_W(IW), .FRAC_W(FW), .LTIME_W(LW)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .wr_int_i(wr_int),
        .wr_frac_i(wr_frac), .bypass_i(bypass), .ltime_i(ltime), .ack_i(ack),
        .tmr_expire_i(tmr), .rd_int_o(rd_int), .rd_frac_o(rd_frac),
        .busy_o(busy), .req_o(req), .app_int_o(app_int), .app_frac_o(app_frac),
        .lock_o(lock), .upd_err_o(upd_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic write(input int i, input int f);
        @(negedge clk);
        wr_en = 1'b1; wr_int = IW'(i); wr_frac = FW'(f);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic relock();
        chk_eq("R6 lock low before expiry", int'(lock), 0);
        tmr = 1'b1;
        @(negedge clk);
        tmr = 1'b0;
        chk_eq("R6 lock set by expiry", int'(lock), 1);
    endtask

    task automatic do_update(input int i, input int f);
        bit chg;
        write(i, f);
        chk_eq("R1 readback int", int'(rd_int), i);
        chk_eq("R1 readback frac", int'(rd_frac), f);
        chk_eq("R2 busy after write", int'(busy), 1);
        chk_eq("R3 no req yet", int'(req), 0);
        @(negedge clk);
        chk_eq("R3 req raised", int'(req), 1);
        @(negedge clk);
        chk_eq("R3 req held", int'(req), 1);
        chk_eq("R3 applied unchanged before ack", int'(app_int), exp_int);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chg = (i != exp_int);
        exp_int = i; exp_frac = f;
        chk_eq("R3 applied int", int'(app_int), exp_int);
        chk_eq("R3 applied frac", int'(app_frac), exp_frac);
        chk_eq("R2 busy cleared", int'(busy), 0);
        chk_eq("R3 req dropped", int'(req), 0);
        if (chg) begin
            chk_eq("R4 lock cleared on int change", int'(lock), 0);
            @(negedge clk);
            relock();
        end else begin
            chk_eq("R5 lock kept on frac-only change", int'(lock), 1);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R9 reset readback", int'(rd_int), 0);
        chk_eq("R9 reset applied", int'(app_int), 0);
        chk_eq("R9 reset busy", int'(busy), 0);
        chk_eq("R9 reset req", int'(req), 0);
        chk_eq("R9 reset err", int'(upd_err), 0);
        chk_eq("R6 lock low after reset", int'(lock), 0);
        relock();

        for (int i = 0; i < (1 << IW); i++)
            for (int f = 0; f < (1 << FW); f++)
                do_update(i, f);

        // R8: writes queued during an open transfer, last one wins
        write(3, 1);
        @(negedge clk);
        chk_eq("R8 first req", int'(req), 1);
        write(7, 2);
        write(9, 3);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk_eq("R8 first value applied", int'(app_int), 3);
        chk_eq("R8 busy stays for queued write", int'(busy), 1);
        chk_eq("R8 lock dropped", int'(lock), 0);
        @(negedge clk);
        chk_eq("R8 second req", int'(req), 1);
        chk_eq("R8 readback shows latest", int'(rd_int), 9);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk_eq("R8 latest int applied", int'(app_int), 9);
        chk_eq("R8 latest frac applied", int'(app_frac), 3);
        chk_eq("R8 busy cleared", int'(busy), 0);
        exp_int = 9; exp_frac = 3;
        @(negedge clk);
        relock();

        // settings sweep: bypass x lock-time code
        for (int b = 0; b < 2; b++)
            for (int t = 0; t < (1 << LW); t++) begin
                bypass = b[0]; ltime = LW'(t);
                if (b == 0 && t != 0) begin
                    do_update((exp_int + 5) % 16, (exp_frac + 1) % 4);
                    chk_eq("R7 no error on valid settings", int'(upd_err), 0);
                end
            end
        for (int b = 0; b < 2; b++)
            for (int t = 0; t < (1 << LW); t++) begin
                if (!(b == 0 && t != 0)) begin
                    int ni;
                    bypass = b[0]; ltime = LW'(t);
                    ni = (exp_int + 3) % 16;
                    write(ni, 2);
                    chk_eq("R1 readback on invalid write", int'(rd_int), ni);
                    chk_eq("R7 error set", int'(upd_err), 1);
                    chk_eq("R7 no busy", int'(busy), 0);
                    repeat (3) begin
                        @(negedge clk);
                        chk_eq("R7 no req", int'(req), 0);
                    end
                    chk_eq("R7 applied int unchanged", int'(app_int), exp_int);
                    chk_eq("R7 applied frac unchanged", int'(app_frac), exp_frac);
                    chk_eq("R7 lock unchanged", int'(lock), 1);
                end
            end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule